// File: doc/BRIEF.md
# Serial Successive-Approximation Converter (Digital Model)

This block is the device-side digital logic of a 12-bit successive-approximation converter that has a three-wire serial output. The analog comparator is replaced by a digital sample word. The block takes the sample when the host pulls chip select low. It then resolves one result bit on each rising edge of the serial clock and shifts that bit out on the same edge. The data pin is driven through an output enable so that the pin can be tri-stated outside the block. An active-low shutdown input stops all activity.

All inputs are sampled by the block clock `clk`. Serial-clock and chip-select edges are found by comparing each input with its value one `clk` earlier. Each output changes on the `clk` edge at which the input edge is first seen.

The controller has five states. `ST_OFF` is shutdown. `ST_IDLE` has chip select high and the pin released. `ST_LEAD` drives the zero preamble. `ST_RESOLVE` produces the result bits. `ST_TAIL` drives zeros after the LSB. The transitions are:
- OFF_TO_IDLE: shutdown is released with no chip-select fall.
- START: an accepted chip-select fall, taken from IDLE, or from OFF when the fall arrives together with the release of shutdown.
- LEAD_DONE: the 2nd rising serial edge in LEAD.
- LSB_DONE: the rising edge that resolves bit 0 in RESOLVE.
- ABORT: chip select goes high in LEAD, RESOLVE or TAIL, and the block returns to IDLE.
- POWER_DOWN: shutdown is asserted in any state, and the block goes to OFF.

Top module: `sar_serial_adc`

## Requirements
- R1: After reset, `sdo_oe` = 0, `sdo` = 0 and `ready` = 0.
- R2: A falling edge of `cs_n` while `shdn_n` = 1 sets `sdo_oe` = 1 with `sdo` = 0 on the next `clk` edge. It also latches `sample` at that moment, and later changes of `sample` do not affect the result.
- R3: The first 2 rising edges of `sclk` after the start keep `sdo` at 0.
- R4: Rising edges 3 to 14 present the result bits 11 down to 0, MSB first. The coding is straight binary, so 0x000 gives all zeros and 0xFFF gives all ones. Each bit is kept when the latched sample is greater than or equal to the trial code, and cleared otherwise.
- R5: Rising edges after the LSB, while `cs_n` stays low, give `sdo` = 0 with `sdo_oe` still 1, and `ready` stays 1.
- R6: Whenever `cs_n` is high, `sdo_oe` and `sdo` are 0 from the next `clk` edge. An abandoned conversion does not raise `ready`, and the next fall starts a fresh conversion.
- R7: While `shdn_n` = 0, `sdo_oe` = 0 and falls of `cs_n` are ignored, which leaves `ready` unchanged. Asserting shutdown mid-conversion abandons the conversion. Releasing shutdown while `cs_n` is already low does not start a conversion.
- R8: `ready` rises on the same `clk` edge that presents the LSB. It falls only on the next accepted fall of `cs_n`.
- R9: Only a low-to-high change of `sclk` advances the output. Holding `sclk` high, or a falling edge of `sclk`, leaves `sdo` unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock that samples all inputs |
| rst_n | input | 1 | Active-low synchronous reset |
| sclk | input | 1 | Serial clock from the host |
| cs_n | input | 1 | Active-low chip select; its falling edge starts a conversion |
| shdn_n | input | 1 | Active-low shutdown |
| sample | input | 12 | Digital stand-in for the analog input |
| sdo | output | 1 | Serial data, driven only while `sdo_oe` = 1 |
| sdo_oe | output | 1 | Output enable for the external tri-state pin driver |
| ready | output | 1 | Conversion-complete flag |

## Verification
The checker assumes that `sclk`, `cs_n` and `shdn_n` are already synchronous to `clk` and never change twice within one `clk` period. It also assumes that `cs_n` is held high during reset, because edge detection starts from an idle level. The bench changes every input only on the falling edge of `clk`. It keeps each `sclk` level for at least one full `clk` period and releases reset with chip select high. This keeps every edge the checker reasons about visible for exactly one sample.

// File: rtl/sar_serial_pkg.sv
package sar_serial_pkg;

    typedef enum logic [2:0] {
        ST_OFF     = 3'd0,
        ST_IDLE    = 3'd1,
        ST_LEAD    = 3'd2,
        ST_RESOLVE = 3'd3,
        ST_TAIL    = 3'd4
    } conv_state_t;

    function automatic logic is_driving(input conv_state_t s);
        return (s == ST_LEAD) || (s == ST_RESOLVE) || (s == ST_TAIL);
    endfunction

endpackage

// File: rtl/sar_edge_seen.sv
module sar_edge_seen #(
    parameter logic IDLE_LEVEL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic rise,
    output logic fall
);
    logic din_q;

    always_ff @(posedge clk) begin
        if (!rst_n) din_q <= IDLE_LEVEL;
        else        din_q <= din;
    end

    assign rise = din & ~din_q;
    assign fall = ~din & din_q;
endmodule

// File: rtl/sar_step_core.sv
module sar_step_core #(
    parameter int WIDTH = 12,
    localparam int IW = (WIDTH > 1) ? $clog2(WIDTH) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             step,
    input  logic [WIDTH-1:0] sample,
    output logic             bit_out,
    output logic             last
);
    logic [WIDTH-1:0] held;
    logic [WIDTH-1:0] result;
    logic [WIDTH-1:0] probe;
    logic [WIDTH-1:0] trial;
    logic [IW-1:0]    idx;

    for (genvar g = 0; g < WIDTH; g++) begin : g_probe
        assign probe[g] = (idx == IW'(g));
    end

    assign trial   = result | probe;
    assign bit_out = (held >= trial);
    assign last    = (idx == '0);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            held   <= '0;
            result <= '0;
            idx    <= IW'(WIDTH - 1);
        end else if (load) begin
            held   <= sample;
            result <= '0;
            idx    <= IW'(WIDTH - 1);
        end else if (step) begin
            if (bit_out) result <= trial;
            if (!last)   idx    <= idx - 1'b1;
        end
    end
endmodule

// File: rtl/sar_serial_adc.sv
module sar_serial_adc
    import sar_serial_pkg::*;
#(
    parameter int WIDTH = 12,
    parameter int LEAD  = 2,
    localparam int LW = $clog2(LEAD + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sclk,
    input  logic             cs_n,
    input  logic             shdn_n,
    input  logic [WIDTH-1:0] sample,
    output logic             sdo,
    output logic             sdo_oe,
    output logic             ready
);
    conv_state_t state, st_next;
    logic        sclk_rise, sclk_fall_unused;
    logic        cs_rise_unused, cs_fall;
    logic        accept;
    logic        core_bit, core_last;
    logic        core_step;
    logic [LW-1:0] lead_cnt;

    sar_edge_seen #(.IDLE_LEVEL(1'b0)) u_sclk_edge (
        .clk(clk), .rst_n(rst_n), .din(sclk),
        .rise(sclk_rise), .fall(sclk_fall_unused)
    );

    sar_edge_seen #(.IDLE_LEVEL(1'b1)) u_cs_edge (
        .clk(clk), .rst_n(rst_n), .din(cs_n),
        .rise(cs_rise_unused), .fall(cs_fall)
    );

    assign accept    = shdn_n && cs_fall;
    assign core_step = (state == ST_RESOLVE) && sclk_rise && is_driving(st_next);

    sar_step_core #(.WIDTH(WIDTH)) u_core (
        .clk(clk), .rst_n(rst_n),
        .load(accept), .step(core_step), .sample(sample),
        .bit_out(core_bit), .last(core_last)
    );

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= st_next;
    end

    // transitions
    always_comb begin
        st_next = state;
        if (!shdn_n) begin
            st_next = ST_OFF;                               // POWER_DOWN
        end else begin
            unique case (state)
                ST_OFF:     st_next = cs_fall ? ST_LEAD : ST_IDLE;   // START / OFF_TO_IDLE
                ST_IDLE:    if (cs_fall) st_next = ST_LEAD;          // START
                ST_LEAD: begin
                    if (cs_n) st_next = ST_IDLE;                     // ABORT
                    else if (sclk_rise && lead_cnt == LW'(LEAD - 1))
                        st_next = ST_RESOLVE;                        // LEAD_DONE
                end
                ST_RESOLVE: begin
                    if (cs_n) st_next = ST_IDLE;                     // ABORT
                    else if (sclk_rise && core_last)
                        st_next = ST_TAIL;                           // LSB_DONE
                end
                ST_TAIL:    if (cs_n) st_next = ST_IDLE;             // ABORT
                default:    st_next = ST_IDLE;
            endcase
        end
    end

    // preamble edge counter
    always_ff @(posedge clk) begin
        if (!rst_n || accept)                     lead_cnt <= '0;
        else if (state == ST_LEAD && sclk_rise)   lead_cnt <= lead_cnt + 1'b1;
    end

    // outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sdo    <= 1'b0;
            sdo_oe <= 1'b0;
            ready  <= 1'b0;
        end else begin
            sdo_oe <= is_driving(st_next);
            if (!is_driving(st_next))  sdo <= 1'b0;
            else if (core_step)        sdo <= core_bit;
            else if (sclk_rise)        sdo <= 1'b0;
            if (accept)                                 ready <= 1'b0;
            else if (core_step && core_last)            ready <= 1'b1;
        end
    end
endmodule

// File: rtl/sar_serial_adc_chk.sv
module sar_serial_adc_chk (
    input logic clk,
    input logic rst_n,
    input logic sclk,
    input logic cs_n,
    input logic shdn_n,
    input logic sdo,
    input logic sdo_oe,
    input logic ready
);
    AST_RESET_QUIET: assert property (@(posedge clk) !rst_n |=> (!sdo_oe && !sdo && !ready)); // R1

    AST_START_DRIVES: assert property (@(posedge clk) disable iff (!rst_n)
        (shdn_n && $fell(cs_n)) |=> (sdo_oe && !sdo && !ready)); // R2

    AST_CS_HIGH_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |=> (!sdo_oe && !sdo)); // R6

    AST_OFF_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        !shdn_n |=> !sdo_oe); // R7

    AST_READY_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && !(shdn_n && $fell(cs_n))) |=> ready); // R8

    AST_SDO_ON_RISE_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        (sdo_oe && !cs_n && shdn_n && !(sclk && !$past(sclk))) |=> $stable(sdo)); // R9
endmodule

bind sar_serial_adc sar_serial_adc_chk u_chk (
    .clk(clk), .rst_n(rst_n), .sclk(sclk), .cs_n(cs_n), .shdn_n(shdn_n),
    .sdo(sdo), .sdo_oe(sdo_oe), .ready(ready)
);

// File: tb/test_sar_serial_adc.sv
module test_sar_serial_adc;
    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 8;
    localparam logic [11:0] VEC [NVEC] = '{12'h000, 12'hFFF, 12'h800, 12'h001,
                                          12'hA5A, 12'h5A5, 12'h7FF, 12'h123};

    logic clk = 0, rst_n = 0, sclk = 0, cs_n = 1, shdn_n = 1;
    logic [11:0] sample = '0;
    logic sdo, sdo_oe, ready;
    int n_chk = 0, n_bad = 0, cycles = 0;
    bit done = 0;

    sar_serial_adc i_sar_serial_adc (
        .clk(clk), .rst_n(rst_n), .sclk(sclk), .cs_n(cs_n), .shdn_n(shdn_n),
        .sample(sample), .sdo(sdo), .sdo_oe(sdo_oe), .ready(ready)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string req, input logic got, input logic exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %b expected %b at %0t", req, got, exp, $time);
        end
    endtask

    task automatic nclk(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic wrap_up();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    endtask

    // one rising and falling sclk; check sdo while high
    task automatic pulse(input logic exp_sdo, input string req);
        sclk = 1; nclk(1);
        check(req, sdo, exp_sdo);
        sclk = 0; nclk(1);
    endtask

    task automatic start();
        cs_n = 0; nclk(1);
    endtask

    task automatic run_conv(input logic [11:0] s, input int extra);
        sample = s;
        start();
        check("R2 oe", sdo_oe, 1'b1);
        check("R2 sdo", sdo, 1'b0);
        check("R8 clear", ready, 1'b0);
        sample = ~s;                          // R2: must not affect result
        for (int k = 1; k <= 14 + extra; k++) begin
            sclk = 1; nclk(1);
            if (k <= 2)       check("R3 lead", sdo, 1'b0);
            else if (k <= 14) check("R4 bit", sdo, s[14-k]);
            else begin
                check("R5 tail", sdo, 1'b0);
                check("R5 oe", sdo_oe, 1'b1);
            end
            if (k == 13) check("R8 early", ready, 1'b0);
            if (k >= 14) check("R8 set", ready, 1'b1);
            sclk = 0; nclk(1);
        end
        cs_n = 1; nclk(1);
        check("R6 oe", sdo_oe, 1'b0);
        check("R6 sdo", sdo, 1'b0);
        nclk(1);
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 100000 && !done) begin
                n_chk++; n_bad++;
                $display("FAIL watchdog: got timeout expected completion");
                wrap_up();
            end
        end
    end

    initial begin
        nclk(3);
        check("R1 oe", sdo_oe, 1'b0);
        check("R1 sdo", sdo, 1'b0);
        check("R1 ready", ready, 1'b0);
        rst_n = 1; nclk(2);

        for (int v = 0; v < NVEC; v++) run_conv(VEC[v], v % 3);

        // R6 abort mid-conversion, ready stays low, fresh restart
        sample = 12'hFFF; start();
        for (int k = 1; k <= 6; k++) pulse((k >= 3) ? 1'b1 : 1'b0, "R6 pre");
        cs_n = 1; nclk(1);
        check("R6 abort oe", sdo_oe, 1'b0);
        check("R6 abort ready", ready, 1'b0);
        nclk(1);
        run_conv(12'h3C6, 0);

        // R9 sclk held high does not advance
        sample = 12'h800; start();
        pulse(1'b0, "R3"); pulse(1'b0, "R3");
        sclk = 1; nclk(1);
        check("R9 msb", sdo, 1'b1);
        nclk(4);
        check("R9 held", sdo, 1'b1);
        sclk = 0; nclk(2);
        check("R9 fall", sdo, 1'b1);
        pulse(1'b0, "R9 next");
        cs_n = 1; nclk(2);

        // R7 shutdown: fall ignored, ready unchanged (1 from earlier)
        run_conv(12'h00F, 0);
        shdn_n = 0; nclk(1);
        start();
        check("R7 oe", sdo_oe, 1'b0);
        check("R7 ready", ready, 1'b1);
        pulse(1'b0, "R7 sdo");
        shdn_n = 1; nclk(2);
        check("R7 no start", sdo_oe, 1'b0);
        cs_n = 1; nclk(2);

        // R7 shutdown mid-conversion
        sample = 12'hFFF; start();
        for (int k = 1; k <= 4; k++) pulse((k >= 3) ? 1'b1 : 1'b0, "R7 pre");
        shdn_n = 0; nclk(1);
        check("R7 mid oe", sdo_oe, 1'b0);
        check("R7 mid sdo", sdo, 1'b0);
        check("R7 mid ready", ready, 1'b0);
        cs_n = 1; shdn_n = 1; nclk(2);
        run_conv(12'hC33, 1);

        done = 1;
        wrap_up();
    end
endmodule